// File: doc/BRIEF.md
# Revolution pulse-count integrity checker

This block watches a rotary stage through two synchronized signals: an incremental encoder pulse that advances once per angular step, and an index pulse that marks the reference baseline once per turn. It keeps a running angular count and checks, each time the index pulse arrives, that exactly one full revolution's worth of pulses (2^(CNT_W-1), with CNT_W = 23 by default) has been seen since the previous index pulse. It also catches a revolution that runs long as soon as the count passes the full-turn value, without waiting for the index pulse.

Every detected fault produces a one-cycle error strobe. It also bumps a saturating error counter and latches the angular count at which the fault was seen. A policy input selects what happens next. Either the stage keeps running and the errors are only logged, or a halt request is raised and held until reset. The first index pulse after reset only aligns the count to zero. Before that pulse, encoder pulses are ignored.

Top module: `rev_integrity_chk`

## Requirements
- R1: After reset, angle_cnt_o, err_strobe_o, err_count_o, err_snap_o and halt_req_o are all zero.
- R2: Until the first index pulse after reset, encoder pulses leave angle_cnt_o at zero, and that first index pulse raises no error.
- R3: Once aligned, each encoder pulse raises angle_cnt_o by one on the following cycle. At all-ones the count holds.
- R4: An index pulse reloads angle_cnt_o to zero on the following cycle. An encoder pulse in the same cycle as the index pulse is discarded.
- R5: An index pulse that arrives while angle_cnt_o equals 2^(CNT_W-1) (MSB set, lower bits clear) raises no error.
- R6: An index pulse that arrives while aligned, with any other count and no overrun already reported this revolution, raises an error. The snapshot is the count at the index pulse.
- R7: The encoder pulse that takes the count from 2^(CNT_W-1) to 2^(CNT_W-1)+1 raises one overrun error, with snapshot 2^(CNT_W-1)+1. The index pulse that closes that revolution raises no second error.
- R8: Each error adds one to err_count_o, which saturates at 2^ERR_W-1. err_strobe_o and err_snap_o update in the cycle after the causing event.
- R9: An error taken while halt_on_err_i is high sets halt_req_o in the same cycle as the strobe. halt_req_o then stays high whatever the policy bit does, until reset. With the policy bit low, errors leave halt_req_o low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_pulse_i | input | 1 | Synchronized encoder step pulse, one cycle per step |
| index_pulse_i | input | 1 | Synchronized revolution index pulse |
| halt_on_err_i | input | 1 | Policy: 1 requests a halt on error |
| angle_cnt_o | output | CNT_W | Current angular pulse count |
| err_strobe_o | output | 1 | One-cycle strobe per detected error |
| err_count_o | output | ERR_W | Saturating error total |
| err_snap_o | output | CNT_W | Count seen at the most recent error |
| halt_req_o | output | 1 | Sticky halt request |

## Verification
The bench builds the block with CNT_W = 5 and ERR_W = 3. This makes a revolution 16 pulses long, lets a 35-pulse revolution drive the angle counter into saturation at 31, and saturates the error counter after seven faults. With these values, exact, short, long and saturating revolutions all fit in a few thousand cycles. The run also covers the coincident index/encoder case, the sticky halt, and the return to unaligned state after reset.

// File: rtl/rev_pkg.sv
package rev_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE    = 2'd0,
    CAUSE_INDEX   = 2'd1,
    CAUSE_OVERRUN = 2'd2
  } err_cause_e;

  // Pulses in one full revolution for a counter of width w.
  function automatic int unsigned rev_span(input int unsigned w);
    return 32'd1 << (w - 1);
  endfunction

endpackage

// File: rtl/rev_angle_counter.sv
module rev_angle_counter #(
  parameter int CNT_W = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enc_i,
  input  logic             idx_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             aligned_o,
  output logic             pass_over_o
);
  localparam logic [CNT_W-1:0] TARGET = CNT_W'(rev_pkg::rev_span(CNT_W));

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] c);
    return (c == '1) ? c : c + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_o     <= '0;
      aligned_o <= 1'b0;
    end else if (idx_i) begin
      cnt_o     <= '0;
      aligned_o <= 1'b1;
    end else if (enc_i && aligned_o) begin
      cnt_o <= step(cnt_o);
    end
  end

  // The pulse that pushes the count beyond a full revolution.
  assign pass_over_o = enc_i && !idx_i && aligned_o && (cnt_o == TARGET);

endmodule

// File: rtl/rev_check.sv
module rev_check #(
  parameter int CNT_W = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idx_i,
  input  logic             aligned_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             pass_over_i,
  output logic             err_evt_o,
  output logic [CNT_W-1:0] snap_o
);
  import rev_pkg::*;

  localparam logic [CNT_W-1:0] TARGET = CNT_W'(rev_span(CNT_W));
  localparam logic [CNT_W-1:0] OVER   = TARGET + 1'b1;

  logic       ovr_seen;
  err_cause_e cause;

  always_ff @(posedge clk) begin
    if (!rst_n)           ovr_seen <= 1'b0;
    else if (idx_i)       ovr_seen <= 1'b0;
    else if (pass_over_i) ovr_seen <= 1'b1;
  end

  always_comb begin
    cause = CAUSE_NONE;
    if (pass_over_i && !ovr_seen)
      cause = CAUSE_OVERRUN;
    else if (idx_i && aligned_i && !ovr_seen && (cnt_i != TARGET))
      cause = CAUSE_INDEX;
  end

  assign err_evt_o = (cause != CAUSE_NONE);
  assign snap_o    = (cause == CAUSE_OVERRUN) ? OVER : cnt_i;

endmodule

// File: rtl/rev_err_log.sv
module rev_err_log #(
  parameter int CNT_W = 23,
  parameter int ERR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             err_evt_i,
  input  logic [CNT_W-1:0] snap_i,
  input  logic             halt_on_err_i,
  output logic             strobe_o,
  output logic [ERR_W-1:0] count_o,
  output logic [CNT_W-1:0] snap_o,
  output logic             halt_o
);
  function automatic logic [ERR_W-1:0] sat_inc(input logic [ERR_W-1:0] v);
    return (v == '1) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe_o <= 1'b0;
      count_o  <= '0;
      snap_o   <= '0;
      halt_o   <= 1'b0;
    end else begin
      strobe_o <= err_evt_i;
      if (err_evt_i) begin
        count_o <= sat_inc(count_o);
        snap_o  <= snap_i;
        if (halt_on_err_i) halt_o <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/rev_integrity_chk.sv
module rev_integrity_chk #(
  parameter int CNT_W = 23,
  parameter int ERR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enc_pulse_i,
  input  logic             index_pulse_i,
  input  logic             halt_on_err_i,
  output logic [CNT_W-1:0] angle_cnt_o,
  output logic             err_strobe_o,
  output logic [ERR_W-1:0] err_count_o,
  output logic [CNT_W-1:0] err_snap_o,
  output logic             halt_req_o
);
  logic             aligned_w;
  logic             pass_over_w;
  logic             err_evt_w;
  logic [CNT_W-1:0] snap_w;

  rev_angle_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .enc_i      (enc_pulse_i),
    .idx_i      (index_pulse_i),
    .cnt_o      (angle_cnt_o),
    .aligned_o  (aligned_w),
    .pass_over_o(pass_over_w)
  );

  rev_check #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .idx_i      (index_pulse_i),
    .aligned_i  (aligned_w),
    .cnt_i      (angle_cnt_o),
    .pass_over_i(pass_over_w),
    .err_evt_o  (err_evt_w),
    .snap_o     (snap_w)
  );

  rev_err_log #(.CNT_W(CNT_W), .ERR_W(ERR_W)) u_log (
    .clk          (clk),
    .rst_n        (rst_n),
    .err_evt_i    (err_evt_w),
    .snap_i       (snap_w),
    .halt_on_err_i(halt_on_err_i),
    .strobe_o     (err_strobe_o),
    .count_o      (err_count_o),
    .snap_o       (err_snap_o),
    .halt_o       (halt_req_o)
  );

endmodule

// File: rtl/rev_integrity_sva.sv
module rev_integrity_sva #(
  parameter int CNT_W = 23,
  parameter int ERR_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enc_i,
  input logic             idx_i,
  input logic             aligned_i,
  input logic [CNT_W-1:0] angle_i,
  input logic             strobe_i,
  input logic [ERR_W-1:0] count_i,
  input logic             halt_i
);
  // R2
  unaligned_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!aligned_i && !idx_i && enc_i) |=> (angle_i == '0));

  // R3
  angle_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_i |=> ((angle_i == $past(angle_i)) || (angle_i == $past(angle_i) + 1'b1)));

  // R4
  index_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_i |=> (angle_i == '0));

  // R8
  err_count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_i |-> ((count_i == $past(count_i) + 1'b1) ||
                  (($past(count_i) == '1) && (count_i == '1))));

  // R8
  err_count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_i |-> $stable(count_i));

  // R9
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_i |=> halt_i);

  // R9
  halt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt_i) |-> strobe_i);

endmodule

bind rev_integrity_chk rev_integrity_sva #(.CNT_W(CNT_W), .ERR_W(ERR_W)) u_sva (
  .clk      (clk),
  .rst_n    (rst_n),
  .enc_i    (enc_pulse_i),
  .idx_i    (index_pulse_i),
  .aligned_i(aligned_w),
  .angle_i  (angle_cnt_o),
  .strobe_i (err_strobe_o),
  .count_i  (err_count_o),
  .halt_i   (halt_req_o)
);

// File: tb/rev_integrity_chk_bench.sv
`timescale 1ns/1ps
module rev_integrity_chk_bench;
  localparam int CW   = 5;
  localparam int EW   = 3;
  localparam int SPAN = 1 << (CW - 1);
  localparam int CMAX = (1 << CW) - 1;
  localparam int EMAX = (1 << EW) - 1;

  logic clk = 1'b0, rst_n = 1'b0, enc = 1'b0, idx = 1'b0, hpol = 1'b0;
  logic [CW-1:0] angle, snap;
  logic [EW-1:0] ecount;
  logic          strobe, halt;

  rev_integrity_chk #(.CNT_W(CW), .ERR_W(EW)) u_rev_integrity_chk (
    .clk(clk), .rst_n(rst_n), .enc_pulse_i(enc), .index_pulse_i(idx),
    .halt_on_err_i(hpol), .angle_cnt_o(angle), .err_strobe_o(strobe),
    .err_count_o(ecount), .err_snap_o(snap), .halt_req_o(halt)
  );

  always #2.5 clk = ~clk;

  typedef struct { int snap; int cnt; } exp_t;
  exp_t q[$];
  int   checks = 0, errors = 0, exp_errs = 0;
  bit   aligned_m = 1'b0, done = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Driver side of the scoreboard: record one expected error.
  task automatic push_err(input int s);
    exp_errs = (exp_errs == EMAX) ? EMAX : exp_errs + 1;
    q.push_back('{s, exp_errs});
  endtask

  task automatic pulse();
    @(negedge clk) enc = 1'b1;
    @(negedge clk) enc = 1'b0;
  endtask

  task automatic index(input bit with_enc);
    @(negedge clk) begin idx = 1'b1; enc = with_enc; end
    @(negedge clk) begin idx = 1'b0; enc = 1'b0; end
  endtask

  // n pulses then an index pulse, expectations from R3..R7.
  task automatic run_rev(input int n);
    if (aligned_m) begin
      if (n > SPAN)       push_err(SPAN + 1);  // R7 overrun at pulse SPAN+1
      else if (n != SPAN) push_err(n);         // R6 short revolution
    end
    repeat (n) pulse();
    chk("R3 angle before index", angle, aligned_m ? ((n > CMAX) ? CMAX : n) : 0);
    index(1'b0);
    aligned_m = 1'b1;
    chk("R4 angle after index", angle, 0);
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    repeat (3) @(negedge clk);
    aligned_m = 1'b0;
    exp_errs  = 0;
    q.delete();
    rst_n = 1'b1;
  endtask

  // Monitor side of the scoreboard.
  always @(negedge clk) begin
    exp_t e;
    if (rst_n && strobe) begin
      if (q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R5 unexpected error strobe: actual snap %0d expected none", snap);
      end else begin
        e = q.pop_front();
        chk("R6 R7 error snapshot", snap, e.snap);
        chk("R8 error count", ecount, e.cnt);
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1
    chk("R1 angle", angle, 0);
    chk("R1 strobe", strobe, 0);
    chk("R1 count", ecount, 0);
    chk("R1 snap", snap, 0);
    chk("R1 halt", halt, 0);
    rst_n = 1'b1;

    // R2: unaligned pulses ignored, first index silent
    repeat (5) pulse();
    chk("R2 unaligned angle", angle, 0);
    index(1'b0);
    aligned_m = 1'b1;
    chk("R2 first index no error", ecount, 0);

    run_rev(SPAN);                       // R5 exact
    chk("R5 exact revolution", ecount, 0);
    run_rev(10);                         // R6 short
    run_rev(20);                         // R7 overrun, single error
    repeat (2) @(negedge clk);
    chk("R7 one error per long revolution", ecount, 2);
    run_rev(35);                         // R3 saturation at CMAX, R7

    // R4: coincident encoder pulse with index is discarded
    repeat (SPAN) pulse();
    index(1'b1);
    chk("R4 coincident pulse dropped", angle, 0);
    run_rev(SPAN);
    chk("R9 no halt with policy low", halt, 0);

    // R8 saturation
    repeat (5) run_rev(3);
    repeat (2) @(negedge clk);
    chk("R8 saturated count", ecount, EMAX);

    // R9 halt request and stickiness
    hpol = 1'b1;
    run_rev(4);
    chk("R9 halt raised", halt, 1);
    hpol = 1'b0;
    run_rev(SPAN);
    chk("R9 halt sticky", halt, 1);

    // R1 after reset, R2 realignment
    do_reset();
    @(negedge clk);
    chk("R1 halt cleared", halt, 0);
    chk("R1 count cleared", ecount, 0);
    run_rev(7);
    run_rev(SPAN);
    chk("R2 realigned no error", ecount, 0);

    repeat (3) @(negedge clk);
    chk("R6 scoreboard drained", q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule